// File: doc/BRIEF.md
# Clock Buffer Configuration Register Slave

This block is the two-wire serial slave that gives a system host read and write access to the configuration bytes of a clock buffer. Each byte drives a group of output-buffer enables elsewhere in the chip. The register contents appear on a flat parallel bus. The bytes take their default values at reset, so the buffer works even if the host never uses the interface.

SCL and SDA are sampled through two-flop synchronisers running on the system clock. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits are taken on SCL rising edges. The slave changes its SDA drive only after SCL has fallen. It never drives SDA high: it either pulls the line low or releases it.

After the address byte comes a command byte, and bit 7 of the command chooses the access mode. When bit 7 is set, bits 6:0 index one register. When bit 7 is clear, the access is a block access that starts at register 0 and counts upward. A block write carries a count byte ahead of its data. A block read is a repeated START followed by the address with the read bit set, and the slave answers with a count byte and then register 0, register 1 and so on.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: At reset every byte of `cfg_q` equals the matching byte of `DFLT`, and `sda_pull` is 0.
- R2: The slave pulls SDA low in the ACK slot only for the address byte {7'h6E, rw}, where rw=0 means write and rw=1 means read. For any other address it does not ACK, and no register changes for the rest of that transaction.
- R3: A command byte with bit 7 = 1 selects the register at offset bits 6:0. The next byte is written into that register only, and the slave ACKs the command and the data. A register changes only in the cycle in which the slave begins the ACK for that byte, and only while SCL is low.
- R4: A command byte of 8'h00 followed by a count byte starts a block write. The data bytes that follow go to registers 0, 1, 2 and so on, and the count byte does not limit them. If a STOP comes after any complete byte, the bytes already written keep their new values. Each write changes at most one register byte.
- R5: After a byte-mode command, a repeated START with the read address makes the slave return the selected register, most significant bit first.
- R6: After command 8'h00, a repeated START with the read address makes the slave return a count byte equal to NREG, then register 0, register 1 and onward.
- R7: When the master does not ACK a byte it has read, the slave stops transmitting and releases SDA. Any further clocked bits read as 1 until the next START.
- R8: The slave ACKs a byte write to an offset at or above NREG but changes no register. A byte read from such an offset returns 8'h00.
- R9: The slave changes `sda_pull` only while SCL is low, so SDA stays stable for the whole time SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND) |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_q | output | NREG*8 | Register contents, byte i at bits 8*i+7:8*i |

## Verification
The bench uses the default NREG = 6 and a DFLT in which every byte differs. A write that lands in the wrong register therefore shows up as a changed neighbour. Because the offset field is seven bits wide and only six registers exist, offsets from 6 to 127 can be reached, and so both out-of-range behaviours can be exercised. Block transfers run to the last register, and a partial block write stops after two bytes, so the stop-anywhere rule is tested against registers that keep their old values.

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave #(
  parameter int                NREG     = 6,
  parameter logic [6:0]        DEV_ADDR = 7'h6E,
  parameter logic [NREG*8-1:0] DFLT     = 48'h5AC30FFFE781
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NREG*8-1:0] cfg_q
);

  localparam int         PW       = 7;
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} st_t;

  st_t           st;
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic [3:0]    bitcnt;
  logic [7:0]    sreg, txb, rd_val, nxt_tx;
  logic [PW-1:0] ptr;
  logic          ack_ph, mack, blk, send_cnt;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end = scl_fall & ~ack_ph & (bitcnt == 4'd8);
  wire wr_en    = ~start_c & ~stop_c & byte_end & (st == S_WR);

  assign nxt_tx = send_cnt ? CNT_BYTE : rd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[8*g+:8] <= DFLT[8*g+:8];
      else if (wr_en && ptr == PW'(g))
        cfg_q[8*g+:8] <= sreg;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == PW'(i)) rd_val = cfg_q[8*i+:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      sreg     <= '0;
      txb      <= '0;
      ptr      <= '0;
      ack_ph   <= 1'b0;
      mack     <= 1'b0;
      blk      <= 1'b0;
      send_cnt <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      st       <= S_ADDR;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (!ack_ph) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != S_RD) sreg <= {sreg[6:0], sda_s};
        end else if (st == S_RD) begin
          mack <= ~sda_s;
        end
      end
      if (scl_fall) begin
        if (ack_ph) begin
          ack_ph   <= 1'b0;
          bitcnt   <= '0;
          sda_pull <= 1'b0;
          if (st == S_RD) begin
            if (mack) begin
              txb      <= nxt_tx;
              sda_pull <= ~nxt_tx[7];
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr      <= ptr + 7'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        end else if (bitcnt == 4'd8) begin
          ack_ph <= 1'b1;
          if (st == S_RD) begin
            sda_pull <= 1'b0;
            mack     <= 1'b0;
          end else begin
            case (st)
              S_ADDR: begin
                if (sreg[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1;
                  if (sreg[0]) begin
                    st       <= S_RD;
                    mack     <= 1'b1;
                    send_cnt <= blk;
                  end else begin
                    st <= S_CMD;
                  end
                end else begin
                  st <= S_IDLE;
                end
              end
              S_CMD: begin
                sda_pull <= 1'b1;
                blk      <= ~sreg[7];
                ptr      <= sreg[7] ? sreg[6:0] : '0;
                st       <= sreg[7] ? S_WR : S_CNT;
              end
              S_CNT: begin
                sda_pull <= 1'b1;
                st       <= S_WR;
              end
              S_WR: begin
                sda_pull <= 1'b1;
                ptr      <= ptr + 7'd1;
              end
              default: ;
            endcase
          end
        end else if (st == S_RD) begin
          sda_pull <= ~txb[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

endmodule

// File: rtl/clkbuf_cfg_slave_chk.sv
module clkbuf_cfg_slave_chk #(
  parameter int NREG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_pull,
  input logic [NREG*8-1:0] cfg_q
);

  logic [NREG*8-1:0] prev_cfg;
  logic [NREG-1:0]   bdiff;

  always_ff @(posedge clk) prev_cfg <= cfg_q;

  always_comb
    for (int i = 0; i < NREG; i++)
      bdiff[i] = cfg_q[8*i+:8] != prev_cfg[8*i+:8];

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in); // R9

  AST_CFG_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> !scl_in); // R3

  AST_CFG_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $rose(sda_pull)); // R3

  AST_ONE_BYTE_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bdiff) <= 1); // R4

endmodule

bind clkbuf_cfg_slave clkbuf_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull), .cfg_q(cfg_q)
);

// File: tb/clkbuf_cfg_slave_tb.sv
module clkbuf_cfg_slave_tb;
  localparam int          NREG = 6;
  localparam logic [47:0] DFLT = 48'h5AC30FFFE781;
  localparam int          Q    = 10;

  logic        clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_pull, sda_bus;
  logic [47:0] cfg_q;
  logic [7:0]  model [NREG];
  int          checks = 0, fails = 0, unstable = 0;

  assign sda_bus = sda_m & ~sda_pull;
  always #10 clk = ~clk;

  clkbuf_cfg_slave #(.NREG(NREG), .DFLT(DFLT)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .cfg_q(cfg_q));

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_cfg(string req);
    for (int i = 0; i < NREG; i++) check8(req, cfg_q[8*i+:8], model[i]);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbit(logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic rbit(output logic b);
    logic s0;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q/2); s0 = sda_bus; wt(Q/2);
    b = sda_bus; wt(Q/2);
    if (sda_bus !== s0 || b !== s0) unstable++;
    wt(Q/2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  task automatic t_reset();
    check_cfg("R1");
    check8("R1", {7'd0, sda_pull}, 8'h00);
  endtask

  task automatic t_foreign();
    logic a;
    m_start();
    wbyte(8'hA0, a); check8("R2", {7'd0, a}, 8'h00);
    wbyte(8'h82, a); wbyte(8'h99, a);
    m_stop();
    check_cfg("R2");
  endtask

  task automatic t_byte_write(logic [6:0] off, logic [7:0] d, string req);
    logic a;
    m_start();
    wbyte(8'hDC, a);       check8("R2", {7'd0, a}, 8'h01);
    wbyte({1'b1, off}, a); check8(req, {7'd0, a}, 8'h01);
    wbyte(d, a);           check8(req, {7'd0, a}, 8'h01);
    m_stop();
    if (off < NREG) model[off] = d;
    check_cfg(req);
  endtask

  task automatic t_byte_read(logic [6:0] off, logic [7:0] exp, string req);
    logic a;
    logic [7:0] d;
    m_start();
    wbyte(8'hDC, a);
    wbyte({1'b1, off}, a);
    m_start();
    wbyte(8'hDD, a); check8("R2", {7'd0, a}, 8'h01);
    rbyte(d, 1'b0);  check8(req, d, exp);
    check8("R7", {7'd0, sda_pull}, 8'h00);
    rbyte(d, 1'b0);  check8("R7", d, 8'hFF);
    m_stop();
  endtask

  task automatic t_block_write(int n, logic [47:0] v);
    logic a;
    m_start();
    wbyte(8'hDC, a);
    wbyte(8'h00, a); check8("R4", {7'd0, a}, 8'h01);
    wbyte(8'(NREG), a);
    for (int i = 0; i < n; i++) begin
      wbyte(v[8*i+:8], a); check8("R4", {7'd0, a}, 8'h01);
      model[i] = v[8*i+:8];
    end
    m_stop();
    check_cfg("R4");
  endtask

  task automatic t_block_read();
    logic a;
    logic [7:0] d;
    m_start();
    wbyte(8'hDC, a);
    wbyte(8'h00, a);
    m_start();
    wbyte(8'hDD, a);
    rbyte(d, 1'b1); check8("R6", d, 8'(NREG));
    for (int i = 0; i < NREG; i++) begin
      rbyte(d, i != NREG - 1);
      check8("R6", d, model[i]);
    end
    check8("R7", {7'd0, sda_pull}, 8'h00);
    m_stop();
  endtask

  initial begin
    wt(200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = DFLT[8*i+:8];
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_foreign();
    t_byte_write(7'd2, 8'h3C, "R3");
    t_byte_write(7'd5, 8'hA5, "R3");
    t_byte_read(7'd2, model[2], "R5");
    t_byte_read(7'd3, model[3], "R5");
    t_block_write(2, 48'h0000_0000_2211);
    t_block_read();
    t_byte_write(7'h10, 8'h77, "R8");
    t_byte_read(7'h10, 8'h00, "R8");
    t_byte_read(7'h7F, 8'h00, "R8");
    t_block_write(6, 48'h665544332211 ^ 48'h0F0F0F0F0F0F);
    t_block_read();
    t_byte_read(7'd5, model[5], "R5");
    check8("R9", 8'(unstable), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule